// File: doc/BRIEF.md
# Clock Alarm Interrupt Controller

This block sits next to a clock-conditioning PLL and turns three live alarm conditions into software-visible state and pin-level signals. The conditions are loss of signal on clock input 1, loss of signal on clock input 2, and PLL loss of lock. The detectors themselves live elsewhere and deliver their live status as synchronous inputs. A per-input monitor-enable field can suppress either loss-of-signal input.

Each condition feeds a sticky flag. The flag is set whenever the gated live status is high. Software clears a flag by writing 0 to its bit. Per-source mask bits select which flags feed a single registered interrupt level.

Three output pins carry the results, each with a programmable active level:

- Shared pin A carries either the interrupt or the input-1 alarm, as a routing bit selects.
- Pin B carries the input-2 alarm and can be tristated.
- A third pin always carries the lock-loss alarm.

A small register port gives write access and combinational read access to every control and status field.

Top module: `clkmon_irq_ctrl`

## Requirements
- R1: After reset, the flag register (address 1) reads 0x07, the mask register (address 2) reads 0x07, the pin control register (address 3) reads 0x00, and the monitor-enable register (address 4) reads 0x0F.
- R2: The monitor-enable register holds two 2-bit fields, bits [1:0] for input 1 and bits [3:2] for input 2. A field of 00 (off) or 01 (reserved) forces that input's live status to 0. A field of 10 or 11 passes the raw status through. Live status reads at address 0 with bit 0 = input-1 loss, bit 1 = input-2 loss and bit 2 = lock loss.
- R3: A flag (address 1, same bit order as address 0) becomes 1 at the clock edge after its live status is 1. It then stays 1 after the live status returns to 0.
- R4: A write to address 1 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged.
- R5: When a clearing write and a live status of 1 hit the same flag in the same cycle, the flag remains 1.
- R6: A write to the mask register (address 2, same bit order) never changes any flag.
- R7: The interrupt level is the OR of all flags whose mask bit is 0, taken through one register stage. A change in flags or mask therefore appears on the interrupt one clock edge after it takes effect.
- R8: Pin A is always driven. With routing bit (address 3 bit 0) at 1 it carries the interrupt level with polarity bit 2. With routing bit at 0 it carries the input-1 live status with polarity bit 3.
- R9: Pin B's output enable equals address 3 bit 1. Its data is the input-2 live status with polarity bit 3.
- R10: The lock-loss pin carries the lock-loss live status with polarity bit 4. For every polarity bit, 0 means active low and 1 means active high.
- R11: Reads are combinational. Unused bits read 0, and addresses 5 to 7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| los1_raw | input | 1 | Live loss-of-signal status, clock input 1 |
| los2_raw | input | 1 | Live loss-of-signal status, clock input 2 |
| lol_raw | input | 1 | Live PLL loss-of-lock status |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| pin_a_out | output | 1 | Shared pin A: interrupt or input-1 alarm |
| pin_b_out | output | 1 | Pin B data: input-2 alarm |
| pin_b_oe | output | 1 | Pin B output enable |
| lol_pin_out | output | 1 | Lock-loss alarm pin |

## Verification
The hardest situation to reach is a clearing write that lands in the same cycle as a still-asserted live status. To get there, the stimulus holds the lock-loss input high across the write strobe so that the set and the clear meet at one edge.

The one-cycle interrupt latency is checked by changing the mask and sampling pin A both before and after the following edge. The reserved monitor-enable code is driven while its loss input is high, and both live status and flag are then read back.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned NUM_LOS  = 2;
  localparam int unsigned NUM_SRC  = NUM_LOS + 1;
  localparam int unsigned CTL_W    = 5;
  localparam int unsigned LOSEN_W  = 2 * NUM_LOS;

  localparam logic [ADDR_W-1:0] A_LIVE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTL   = 3'd3;
  localparam logic [ADDR_W-1:0] A_LOSEN = 3'd4;

  // pin control bit positions
  localparam int unsigned CTL_ROUTE   = 0;
  localparam int unsigned CTL_B_EN    = 1;
  localparam int unsigned CTL_IRQ_POL = 2;
  localparam int unsigned CTL_BAD_POL = 3;
  localparam int unsigned CTL_LOL_POL = 4;

  typedef struct packed {
    logic lol_pol;
    logic bad_pol;
    logic irq_pol;
    logic b_en;
    logic route_irq;
  } pin_ctl_t;

  function automatic logic apply_pol(input logic lvl, input logic pol);
    return pol ? lvl : ~lvl;
  endfunction
endpackage

// File: rtl/clkmon_live_gate.sv
module clkmon_live_gate
  import clkmon_pkg::*;
#(
  parameter int unsigned N_LOS = NUM_LOS,
  localparam int unsigned EN_W = 2 * N_LOS
) (
  input  logic [N_LOS-1:0] los_raw,
  input  logic             lol_raw,
  input  logic [EN_W-1:0]  los_en,
  output logic [N_LOS:0]   live
);
  for (genvar g = 0; g < N_LOS; g++) begin : g_los
    // codes 10 and 11 monitor; 00 and 01 force quiet
    always_comb live[g] = los_raw[g] & los_en[2*g+1];
  end
  always_comb live[N_LOS] = lol_raw;
endmodule

// File: rtl/clkmon_flag_bank.sv
module clkmon_flag_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] live,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_data,
  output logic [N-1:0] flag_q
);
  logic [N-1:0] clr;
  logic [N-1:0] flag_d;
  logic [N-1:0] flag_en;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_comb begin
      clr[g]     = clr_wr & ~clr_data[g];
      flag_d[g]  = live[g] | (flag_q[g] & ~clr[g]);
      flag_en[g] = live[g] | clr[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[g] <= 1'b1;
      else if (flag_en[g]) flag_q[g] <= flag_d[g];
    end
  end
endmodule

// File: rtl/clkmon_irq_merge.sv
module clkmon_irq_merge #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flag_q,
  input  logic [N-1:0] mask_q,
  output logic         irq_q
);
  logic irq_d;

  always_comb irq_d = |(flag_q & ~mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/clkmon_pin_drive.sv
module clkmon_pin_drive
  import clkmon_pkg::*;
(
  input  pin_ctl_t ctl,
  input  logic     irq_lvl,
  input  logic     los1_live,
  input  logic     los2_live,
  input  logic     lol_live,
  output logic     pin_a_out,
  output logic     pin_b_out,
  output logic     pin_b_oe,
  output logic     lol_pin_out
);
  logic a_irq;
  logic a_bad;

  always_comb begin
    a_irq       = apply_pol(irq_lvl, ctl.irq_pol);
    a_bad       = apply_pol(los1_live, ctl.bad_pol);
    pin_a_out   = ctl.route_irq ? a_irq : a_bad;
    pin_b_out   = apply_pol(los2_live, ctl.bad_pol);
    pin_b_oe    = ctl.b_en;
    lol_pin_out = apply_pol(lol_live, ctl.lol_pol);
  end
endmodule

// File: rtl/clkmon_irq_ctrl.sv
module clkmon_irq_ctrl
  import clkmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              los1_raw,
  input  logic              los2_raw,
  input  logic              lol_raw,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pin_a_out,
  output logic              pin_b_out,
  output logic              pin_b_oe,
  output logic              lol_pin_out
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  always_comb rst_q_n = rst_sync[1];

  // write decode
  logic wr_flag, wr_mask, wr_ctl, wr_losen;
  always_comb begin
    wr_flag  = reg_we && (reg_addr == A_FLAG);
    wr_mask  = reg_we && (reg_addr == A_MASK);
    wr_ctl   = reg_we && (reg_addr == A_CTL);
    wr_losen = reg_we && (reg_addr == A_LOSEN);
  end

  // configuration registers
  logic [NUM_SRC-1:0] mask_q,  mask_d;
  pin_ctl_t           ctl_q,   ctl_d;
  logic [LOSEN_W-1:0] losen_q, losen_d;

  always_comb begin
    mask_d  = reg_wdata[NUM_SRC-1:0];
    ctl_d   = pin_ctl_t'(reg_wdata[CTL_W-1:0]);
    losen_d = reg_wdata[LOSEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      mask_q  <= '1;
      ctl_q   <= '0;
      losen_q <= '1;
    end else begin
      if (wr_mask)  mask_q  <= mask_d;
      if (wr_ctl)   ctl_q   <= ctl_d;
      if (wr_losen) losen_q <= losen_d;
    end
  end

  // datapath
  logic [NUM_SRC-1:0] src_live;
  logic [NUM_SRC-1:0] flag_q;
  logic               irq_lvl;

  clkmon_live_gate #(.N_LOS(NUM_LOS)) u_gate (
    .los_raw ({los2_raw, los1_raw}),
    .lol_raw (lol_raw),
    .los_en  (losen_q),
    .live    (src_live)
  );

  clkmon_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .live     (src_live),
    .clr_wr   (wr_flag),
    .clr_data (reg_wdata[NUM_SRC-1:0]),
    .flag_q   (flag_q)
  );

  clkmon_irq_merge #(.N(NUM_SRC)) u_irq (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .flag_q (flag_q),
    .mask_q (mask_q),
    .irq_q  (irq_lvl)
  );

  clkmon_pin_drive u_pins (
    .ctl         (ctl_q),
    .irq_lvl     (irq_lvl),
    .los1_live   (src_live[0]),
    .los2_live   (src_live[1]),
    .lol_live    (src_live[NUM_SRC-1]),
    .pin_a_out   (pin_a_out),
    .pin_b_out   (pin_b_out),
    .pin_b_oe    (pin_b_oe),
    .lol_pin_out (lol_pin_out)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_LIVE:  reg_rdata[NUM_SRC-1:0] = src_live;
      A_FLAG:  reg_rdata[NUM_SRC-1:0] = flag_q;
      A_MASK:  reg_rdata[NUM_SRC-1:0] = mask_q;
      A_CTL:   reg_rdata[CTL_W-1:0]   = ctl_q;
      A_LOSEN: reg_rdata[LOSEN_W-1:0] = losen_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/clkmon_irq_ctrl_checker.sv
module clkmon_irq_ctrl_checker
  import clkmon_pkg::*;
(
  input logic              clk,
  input logic              rst_q_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [NUM_SRC-1:0] src_live,
  input logic [NUM_SRC-1:0] flag_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [LOSEN_W-1:0] losen_q,
  input logic              irq_lvl
);
  logic armed;
  logic wr_flag_c;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) armed <= 1'b0;
    else          armed <= 1'b1;
  end

  always_comb wr_flag_c = reg_we && (reg_addr == A_FLAG);

  // R2: quiet monitor code keeps input-1 live status low
  a_r2_gate_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    (losen_q[1] == 1'b0) |-> (src_live[0] == 1'b0));

  // R3: live status sets its flag at the next edge
  a_r3_live_sets_flag: assert property (@(posedge clk) disable iff (!rst_q_n || !armed)
    (src_live != '0) |=> ((flag_q & $past(src_live)) == $past(src_live)));

  // R4: a flag only falls after a write of 0 to its bit
  a_r4_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_q_n || !armed)
    (($past(flag_q) & ~flag_q) &
     ~({NUM_SRC{$past(wr_flag_c)}} & ~$past(reg_wdata[NUM_SRC-1:0]))) == '0);

  // R6: mask writes leave flags untouched
  a_r6_mask_write_keeps_flags: assert property (@(posedge clk) disable iff (!rst_q_n)
    (reg_we && reg_addr == A_MASK && src_live == '0) |=> $stable(flag_q));

  // R7: interrupt only follows an unmasked flag from the prior cycle
  a_r7_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_q_n || !armed)
    irq_lvl |-> $past((flag_q & ~mask_q) != '0));
endmodule

bind clkmon_irq_ctrl clkmon_irq_ctrl_checker u_checker (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .src_live  (src_live),
  .flag_q    (flag_q),
  .mask_q    (mask_q),
  .losen_q   (losen_q),
  .irq_lvl   (irq_lvl)
);

// File: tb/clkmon_irq_ctrl_bench.sv
`timescale 1ns/1ps
module clkmon_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       los1_raw, los2_raw, lol_raw;
  logic       reg_we;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       pin_a_out, pin_b_out, pin_b_oe, lol_pin_out;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  clkmon_irq_ctrl u_clkmon_irq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .los1_raw(los1_raw), .los2_raw(los2_raw), .lol_raw(lol_raw),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .pin_a_out(pin_a_out), .pin_b_out(pin_b_out), .pin_b_oe(pin_b_oe),
    .lol_pin_out(lol_pin_out)
  );

  // {ctl[4:0], raw {lol,los2,los1}, exp {a, b, b_oe, lol}}
  localparam logic [11:0] VEC [8] = '{
    {5'b00000, 3'b000, 4'b1101},
    {5'b00000, 3'b111, 4'b0000},
    {5'b11010, 3'b001, 4'b1010},
    {5'b11010, 3'b110, 4'b0111},
    {5'b01010, 3'b100, 4'b0010},
    {5'b10000, 3'b010, 4'b1000},
    {5'b00101, 3'b001, 4'b0101},
    {5'b00001, 3'b111, 4'b1000}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_raw(input logic [2:0] r);
    {lol_raw, los2_raw, los1_raw} = r;
  endtask

  function automatic logic [7:0] pins();
    return {4'b0, pin_a_out, pin_b_out, pin_b_oe, lol_pin_out};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    set_raw(3'b000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    rd(3'd1, d); chk("R1 flags", d, 8'h07);
    rd(3'd2, d); chk("R1 mask", d, 8'h07);
    rd(3'd3, d); chk("R1 ctl", d, 8'h00);
    rd(3'd4, d); chk("R1 losen", d, 8'h0F);
    chk("R1 pins", pins(), 8'h0D);

    // R8 R9 R10 pin routing and polarity table (all flags masked)
    foreach (VEC[i]) begin
      wr(3'd3, {3'b0, VEC[i][11:7]});
      set_raw(VEC[i][6:4]);
      step();
      chk($sformatf("R8 R9 R10 vector %0d", i), pins(), {4'b0, VEC[i][3:0]});
    end
    set_raw(3'b000);
    wr(3'd3, 8'h00);

    // R4 clear all
    wr(3'd1, 8'h00);
    rd(3'd1, d); chk("R4 clear all", d, 8'h00);

    // R3 set and hold
    set_raw(3'b010); step(); set_raw(3'b000);
    rd(3'd1, d); chk("R3 set", d, 8'h02);
    step();
    rd(3'd1, d); chk("R3 held", d, 8'h02);

    // R4 write 1 keeps, write 0 clears
    wr(3'd1, 8'h07);
    rd(3'd1, d); chk("R4 write one keeps", d, 8'h02);
    wr(3'd1, 8'h05);
    rd(3'd1, d); chk("R4 write zero clears", d, 8'h00);

    // R5 set wins over same-cycle clear
    set_raw(3'b100); step();
    wr(3'd1, 8'h00);
    rd(3'd1, d); chk("R5 set wins", d, 8'h04);
    rd(3'd0, d); chk("R2 live lol", d, 8'h04);
    set_raw(3'b000);

    // R6 mask write leaves flags
    wr(3'd2, 8'h00);
    rd(3'd1, d); chk("R6 flags after mask write", d, 8'h04);
    rd(3'd2, d); chk("R6 mask readback", d, 8'h00);

    // R7 interrupt on pin A, active high
    wr(3'd3, 8'h05);
    step();
    chk("R7 irq asserted", {7'b0, pin_a_out}, 8'h01);
    wr(3'd2, 8'h07);
    chk("R7 irq lags mask", {7'b0, pin_a_out}, 8'h01);
    step();
    chk("R7 irq masked", {7'b0, pin_a_out}, 8'h00);
    wr(3'd2, 8'h03);
    chk("R7 irq lags unmask", {7'b0, pin_a_out}, 8'h00);
    step();
    chk("R7 irq unmasked", {7'b0, pin_a_out}, 8'h01);
    wr(3'd1, 8'h00);
    step();
    chk("R7 irq cleared", {7'b0, pin_a_out}, 8'h00);

    // R2 monitor enable codes for input 1
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h0D);
    set_raw(3'b001); step();
    rd(3'd0, d); chk("R2 reserved code live", d, 8'h00);
    rd(3'd1, d); chk("R2 reserved code flag", d, 8'h00);
    chk("R2 reserved code pin A", {7'b0, pin_a_out}, 8'h01);
    wr(3'd4, 8'h0C);
    rd(3'd0, d); chk("R2 off code live", d, 8'h00);
    wr(3'd4, 8'h0E);
    rd(3'd0, d); chk("R2 slow code live", d, 8'h01);
    step();
    rd(3'd1, d); chk("R2 slow code flag", d, 8'h01);
    set_raw(3'b000);

    // R11 readback widths and unused addresses
    wr(3'd3, 8'hFF);
    rd(3'd3, d); chk("R11 ctl width", d, 8'h1F);
    rd(3'd5, d); chk("R11 unused address", d, 8'h00);
    rd(3'd7, d); chk("R11 unused address 7", d, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule